// File: doc/BRIEF.md
# Four-Phase Crossbar Training Pulse Generator

This block drives the row and column lines of a two-row resistive crossbar during in-situ perceptron training. Each synaptic weight is held as a differential pair of cells, one on a positive row and one on a negative row. Each training request carries a pattern of NCOL bipolar inputs, the wanted class label and the class the array actually produced. A request whose label and output agree is consumed with no effect. A request whose label and output disagree starts a fixed sequence of four drive phases, with a one-cycle all-zero gap between consecutive phases. All weights are adjusted in parallel. Phases 1 and 2 weaken the positive and negative rows. Phases 3 and 4 strengthen the negative and positive rows.

Every line carries a two-bit ternary code: 2'b00 means zero, 2'b01 means plus half of Vtrain and 2'b11 means minus half. A cell sees the full Vtrain only when its column and its row carry opposite non-zero half levels. A cell on a driven line whose other end is at zero or at the same sign sees at most half of Vtrain, and that is below the switching threshold. The Vtrain amplitude code and the phase width in clock cycles are plain configuration inputs. Both are captured when a correcting request is accepted, so software may raise the amplitude between epochs without disturbing a sequence that is already running.

The request port uses valid/ready. `req_ready` is high exactly when no sequence is running. A request is taken on a cycle where both `req_valid` and `req_ready` are high. While a sequence runs, `req_ready` stays low and the requester must hold its fields. A request with label equal to output is taken in one cycle and leaves the block idle and ready.

Top module: `xbar_train_pulser`

## Requirements
- R1: After reset `busy` is 0, `req_ready` is 1, `vtrain_code` is 0, and every column and row line carries 2'b00.
- R2: `req_ready` equals the inverse of `busy`. A request taken with `req_label == req_out` produces no drive and leaves `busy` low and `vtrain_code` unchanged. A request presented while busy is not taken and does not change the running sequence.
- R3: A request taken with `req_label != req_out` raises `busy` on the next cycle, and `busy` stays high for exactly 4*W+3 cycles. W is the value of `cfg_width` at acceptance.
- R4: Counting the first busy cycle as 0, phase 1 covers cycles [0,W), phase 2 covers [W+1,2W+1), phase 3 covers [2W+2,3W+2) and phase 4 covers [3W+3,4W+3). Cycles W, 2W+1 and 3W+2 are gaps in which every line is 2'b00.
- R5: In every phase, column i (bits 2i+1:2i of `col_lvl`) carries 2'b01 if bit i of the captured pattern is 1 (input +1) and 2'b11 if it is 0 (input -1). Columns carry 2'b00 in gaps and while idle.
- R6: The positive row carries 2'b01 in phase 1 when the captured label is 1 (+1) and 2'b11 when it is 0 (-1). In phase 4 it carries the opposite code. In all other cycles it carries 2'b00.
- R7: The negative row is driven as the positive row would be for the inverted label, but in phase 2 (weaken) and phase 3 (strengthen). So label 1 gives 2'b11 in phase 2 and 2'b01 in phase 3. In all other cycles it carries 2'b00.
- R8: At most one row is non-zero in any cycle, and the code 2'b10 never appears on any line.
- R9: `vtrain_code` takes the value of `cfg_vtrain` when a correcting request is accepted and holds it until the next correcting request. Changes to `cfg_vtrain` or `cfg_width` while busy have no effect on the running sequence.
- R10: A `cfg_width` of 0 is treated as a width of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Training request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_x | input | NCOL | Pattern, bit i = 1 for input +1, 0 for input -1 |
| req_label | input | 1 | Desired class, 1 for +1, 0 for -1 |
| req_out | input | 1 | Actual class produced, 1 for +1, 0 for -1 |
| cfg_width | input | WW | Phase width in cycles (0 acts as 1) |
| cfg_vtrain | input | VW | Training amplitude code for the drivers |
| busy | output | 1 | A four-phase sequence is running |
| vtrain_code | output | VW | Amplitude code captured for the current or last sequence |
| col_lvl | output | 2*NCOL | Column level codes, two bits per column |
| row_pos_lvl | output | 2 | Positive row level code |
| row_neg_lvl | output | 2 | Negative row level code |

## Verification
The hardest condition to reach from the ports is a running sequence that meets hostile inputs in the same cycles. These are a new, differently patterned correcting request held valid, and configuration values that change on every busy cycle. The bench does this on most random requests: each cycle while busy it re-randomises the pattern, the label, the width and the amplitude. It then checks that the lines, the busy length and the amplitude code still follow the values captured at acceptance. Width 0, width 1, all-ones and all-zeros patterns, both labels, and agreeing requests are added as directed cases.

// File: rtl/xtp_pkg.sv
package xtp_pkg;

  localparam int NPHASE = 4;

  // Ternary line code: magnitude zero or half of the training amplitude.
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PH1  = 3'd1,
    ST_GAP1 = 3'd2,
    ST_PH2  = 3'd3,
    ST_GAP2 = 3'd4,
    ST_PH3  = 3'd5,
    ST_GAP3 = 3'd6,
    ST_PH4  = 3'd7
  } seq_st_e;

  // Map a bipolar sign bit (1 = +1) to a half-amplitude level.
  function automatic lvl_e sign_lvl(input logic plus);
    return plus ? LVL_POS : LVL_NEG;
  endfunction

endpackage

// File: rtl/xtp_capture.sv
module xtp_capture #(
  parameter int NCOL = 10,
  parameter int VW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NCOL-1:0] x_in,
  input  logic            label_in,
  input  logic [VW-1:0]   vt_in,
  output logic [NCOL-1:0] x_q,
  output logic            label_q,
  output logic [VW-1:0]   vt_q
);

  // Pattern, label and amplitude are frozen for the whole sequence.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q     <= '0;
      label_q <= 1'b0;
      vt_q    <= '0;
    end else if (load) begin
      x_q     <= x_in;
      label_q <= label_in;
      vt_q    <= vt_in;
    end
  end

endmodule

// File: rtl/xtp_sequencer.sv
module xtp_sequencer
  import xtp_pkg::*;
#(
  parameter int WW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WW-1:0]       width_cfg,
  output logic                busy,
  output logic [NPHASE-1:0]   phase_oh
);

  seq_st_e       state_q, state_d;
  logic [WW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wlen_q, wlen_d;
  logic [WW-1:0] weff;

  // A zero width would make an empty phase; clamp it to one cycle.
  assign weff = (width_cfg == '0) ? WW'(1) : width_cfg;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wlen_d  = wlen_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PH1;
          cnt_d   = weff - WW'(1);
          wlen_d  = weff;
        end
      end
      ST_PH1, ST_PH2, ST_PH3, ST_PH4: begin
        if (cnt_q == '0) begin
          unique case (state_q)
            ST_PH1:  state_d = ST_GAP1;
            ST_PH2:  state_d = ST_GAP2;
            ST_PH3:  state_d = ST_GAP3;
            default: state_d = ST_IDLE;
          endcase
        end else begin
          cnt_d = cnt_q - WW'(1);
        end
      end
      ST_GAP1, ST_GAP2, ST_GAP3: begin
        unique case (state_q)
          ST_GAP1: state_d = ST_PH2;
          ST_GAP2: state_d = ST_PH3;
          default: state_d = ST_PH4;
        endcase
        cnt_d = wlen_q - WW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wlen_q  <= WW'(1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wlen_q  <= wlen_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  always_comb begin
    phase_oh = '0;
    unique case (state_q)
      ST_PH1:  phase_oh[0] = 1'b1;
      ST_PH2:  phase_oh[1] = 1'b1;
      ST_PH3:  phase_oh[2] = 1'b1;
      ST_PH4:  phase_oh[3] = 1'b1;
      default: phase_oh = '0;
    endcase
  end

endmodule

// File: rtl/xtp_col_drive.sv
module xtp_col_drive
  import xtp_pkg::*;
(
  input  logic       active,
  input  logic       x_bit,
  output logic [1:0] lvl
);

  // A column carries its input sign in every phase and rests at zero otherwise.
  always_comb begin
    lvl = LVL_ZERO;
    if (active) lvl = sign_lvl(x_bit);
  end

endmodule

// File: rtl/xtp_row_drive.sv
module xtp_row_drive
  import xtp_pkg::*;
#(
  parameter int WEAKEN_PH = 1,
  parameter int BOOST_PH  = 4,
  parameter bit FLIP      = 1'b0
) (
  input  logic [NPHASE-1:0] phase_oh,
  input  logic              label,
  output logic [1:0]        lvl
);

  logic s;

  // FLIP makes this row follow the opposite label.
  assign s = label ^ FLIP;

  always_comb begin
    lvl = LVL_ZERO;
    if (phase_oh[WEAKEN_PH-1])     lvl = sign_lvl(s);
    else if (phase_oh[BOOST_PH-1]) lvl = sign_lvl(!s);
  end

endmodule

// File: rtl/xbar_train_pulser.sv
module xbar_train_pulser
  import xtp_pkg::*;
#(
  parameter int NCOL = 10,
  parameter int WW   = 8,
  parameter int VW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NCOL-1:0]   req_x,
  input  logic              req_label,
  input  logic              req_out,
  input  logic [WW-1:0]     cfg_width,
  input  logic [VW-1:0]     cfg_vtrain,
  output logic              busy,
  output logic [VW-1:0]     vtrain_code,
  output logic [2*NCOL-1:0] col_lvl,
  output logic [1:0]        row_pos_lvl,
  output logic [1:0]        row_neg_lvl
);

  logic              accept;
  logic              start;
  logic [NPHASE-1:0] phase_oh;
  logic              any_phase;
  logic [NCOL-1:0]   x_q;
  logic              label_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  // Only a misclassified pattern earns a correction.
  assign start     = accept && (req_label != req_out);
  assign any_phase = |phase_oh;

  xtp_capture #(.NCOL(NCOL), .VW(VW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .x_in     (req_x),
    .label_in (req_label),
    .vt_in    (cfg_vtrain),
    .x_q      (x_q),
    .label_q  (label_q),
    .vt_q     (vtrain_code)
  );

  xtp_sequencer #(.WW(WW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .width_cfg (cfg_width),
    .busy      (busy),
    .phase_oh  (phase_oh)
  );

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    xtp_col_drive u_col (
      .active (any_phase),
      .x_bit  (x_q[i]),
      .lvl    (col_lvl[2*i +: 2])
    );
  end

  // Positive row: weaken in phase 1, strengthen in phase 4.
  xtp_row_drive #(.WEAKEN_PH(1), .BOOST_PH(4), .FLIP(1'b0)) u_row_pos (
    .phase_oh (phase_oh),
    .label    (label_q),
    .lvl      (row_pos_lvl)
  );

  // Negative row: opposite label, weaken in phase 2, strengthen in phase 3.
  xtp_row_drive #(.WEAKEN_PH(2), .BOOST_PH(3), .FLIP(1'b1)) u_row_neg (
    .phase_oh (phase_oh),
    .label    (label_q),
    .lvl      (row_neg_lvl)
  );

endmodule

// File: rtl/xbar_train_pulser_chk.sv
module xbar_train_pulser_chk #(
  parameter int NCOL = 10,
  parameter int VW   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_label,
  input logic              req_out,
  input logic              busy,
  input logic [VW-1:0]     vtrain_code,
  input logic [2*NCOL-1:0] col_lvl,
  input logic [1:0]        row_pos_lvl,
  input logic [1:0]        row_neg_lvl
);

  logic cols_live, cols_quiet, bad_code, rows_quiet;

  always_comb begin
    cols_live  = 1'b1;
    cols_quiet = 1'b1;
    bad_code   = (row_pos_lvl == 2'b10) || (row_neg_lvl == 2'b10);
    for (int i = 0; i < NCOL; i++) begin
      if (col_lvl[2*i +: 2] == 2'b00) cols_live  = 1'b0;
      else                            cols_quiet = 1'b0;
      if (col_lvl[2*i +: 2] == 2'b10) bad_code   = 1'b1;
    end
  end

  assign rows_quiet = (row_pos_lvl == 2'b00) && (row_neg_lvl == 2'b00);

  // R2
  agree_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_label == req_out)) |=> !busy);

  // R3
  disagree_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_label != req_out)) |=> busy);

  // R3
  ends_on_pos_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(row_pos_lvl) != 2'b00));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cols_quiet && rows_quiet));

  // R4
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rows_quiet) |-> cols_quiet);

  // R5
  cols_with_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rows_quiet |-> cols_live);

  // R5
  cols_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cols_live && $past(cols_live) && $past(busy)) |-> $stable(col_lvl));

  // R8
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((row_pos_lvl != 2'b00) && (row_neg_lvl != 2'b00)));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_code);

  // R9
  vtrain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vtrain_code));

endmodule

bind xbar_train_pulser xbar_train_pulser_chk #(.NCOL(NCOL), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_label   (req_label),
  .req_out     (req_out),
  .busy        (busy),
  .vtrain_code (vtrain_code),
  .col_lvl     (col_lvl),
  .row_pos_lvl (row_pos_lvl),
  .row_neg_lvl (row_neg_lvl)
);

// File: tb/xbar_train_pulser_test.sv
module xbar_train_pulser_test;

  localparam int NCOL = 10;
  localparam int WW   = 8;
  localparam int VW   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [NCOL-1:0]   req_x = '0;
  logic              req_label = 1'b0;
  logic              req_out = 1'b0;
  logic [WW-1:0]     cfg_width = '0;
  logic [VW-1:0]     cfg_vtrain = '0;
  logic              busy;
  logic [VW-1:0]     vtrain_code;
  logic [2*NCOL-1:0] col_lvl;
  logic [1:0]        row_pos_lvl;
  logic [1:0]        row_neg_lvl;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [VW-1:0] last_vt = '0;

  always #10 clk = ~clk;

  xbar_train_pulser #(.NCOL(NCOL), .WW(WW), .VW(VW)) uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_x (req_x), .req_label (req_label), .req_out (req_out),
    .cfg_width (cfg_width), .cfg_vtrain (cfg_vtrain), .busy (busy),
    .vtrain_code (vtrain_code), .col_lvl (col_lvl),
    .row_pos_lvl (row_pos_lvl), .row_neg_lvl (row_neg_lvl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Phase number (1..4) at busy cycle t, 0 for a gap or idle.
  function automatic int exp_phase(input int t, input int w);
    if (t < w)         return 1;
    if (t == w)        return 0;
    if (t < 2*w + 1)   return 2;
    if (t == 2*w + 1)  return 0;
    if (t < 3*w + 2)   return 3;
    if (t == 3*w + 2)  return 0;
    if (t < 4*w + 3)   return 4;
    return 0;
  endfunction

  function automatic logic [1:0] sgn(input logic plus);
    return plus ? 2'b01 : 2'b11;
  endfunction

  function automatic logic [2*NCOL-1:0] exp_cols(input int ph, input logic [NCOL-1:0] x);
    logic [2*NCOL-1:0] r;
    r = '0;
    if (ph != 0)
      for (int i = 0; i < NCOL; i++) r[2*i +: 2] = sgn(x[i]);
    return r;
  endfunction

  function automatic logic [1:0] exp_pos(input int ph, input logic d);
    if (ph == 1) return sgn(d);
    if (ph == 4) return sgn(!d);
    return 2'b00;
  endfunction

  function automatic logic [1:0] exp_neg(input int ph, input logic d);
    if (ph == 2) return sgn(!d);
    if (ph == 3) return sgn(d);
    return 2'b00;
  endfunction

  // Called at a falling edge with the block idle.
  task automatic do_req(input logic [NCOL-1:0] x, input logic d, input logic y,
                        input logic [WW-1:0] w_cfg, input logic [VW-1:0] v_cfg,
                        input bit meddle);
    int w;
    int ph;
    w = (w_cfg == '0) ? 1 : int'(w_cfg);
    req_x = x; req_label = d; req_out = y;
    cfg_width = w_cfg; cfg_vtrain = v_cfg; req_valid = 1'b1;
    check(req_ready == 1'b1, "R2", "ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    if (d == y) begin
      req_valid = 1'b0;
      for (int k = 0; k < 2; k++) begin
        check(busy == 1'b0, "R2", "agreeing request busy", 32'(busy), 32'd0);
        check(col_lvl == '0 && row_pos_lvl == 2'b00 && row_neg_lvl == 2'b00,
              "R2", "agreeing request lines", 32'(col_lvl), 32'd0);
        check(vtrain_code == last_vt, "R2", "agreeing request amplitude",
              32'(vtrain_code), 32'(last_vt));
        @(negedge clk);
      end
      return;
    end
    for (int t = 0; t <= 4*w + 3; t++) begin
      ph = exp_phase(t, w);
      check(busy == (t < 4*w + 3), "R3", $sformatf("busy t=%0d w=%0d", t, w),
            32'(busy), 32'(t < 4*w + 3));
      check(req_ready == !(t < 4*w + 3), "R2", "ready vs busy",
            32'(req_ready), 32'(!(t < 4*w + 3)));
      check(col_lvl == exp_cols(ph, x), "R5", $sformatf("columns t=%0d ph=%0d", t, ph),
            32'(col_lvl), 32'(exp_cols(ph, x)));
      check(row_pos_lvl == exp_pos(ph, d), "R6", $sformatf("pos row t=%0d ph=%0d", t, ph),
            32'(row_pos_lvl), 32'(exp_pos(ph, d)));
      check(row_neg_lvl == exp_neg(ph, d), "R7", $sformatf("neg row t=%0d ph=%0d", t, ph),
            32'(row_neg_lvl), 32'(exp_neg(ph, d)));
      check(!(row_pos_lvl != 2'b00 && row_neg_lvl != 2'b00), "R8", "both rows driven",
            32'({row_pos_lvl, row_neg_lvl}), 32'd0);
      if (ph == 0 && t < 4*w + 3)
        check(col_lvl == '0, "R4", $sformatf("gap t=%0d", t), 32'(col_lvl), 32'd0);
      check(vtrain_code == v_cfg, "R9", "captured amplitude", 32'(vtrain_code), 32'(v_cfg));
      if (meddle && t < 4*w + 2) begin
        req_valid  = 1'b1;
        req_x      = NCOL'($urandom);
        req_label  = 1'($urandom);
        req_out    = !req_label;
        cfg_width  = WW'($urandom_range(0, 9));
        cfg_vtrain = VW'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    last_vt = v_cfg;
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    check(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
    check(vtrain_code == '0, "R1", "amplitude in reset", 32'(vtrain_code), 32'd0);
    check(col_lvl == '0 && row_pos_lvl == 2'b00 && row_neg_lvl == 2'b00,
          "R1", "lines in reset", 32'(col_lvl), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    do_req(10'b10_1100_1010, 1'b1, 1'b0, 8'd3, 6'd36, 1'b0); // label +1
    do_req(10'b10_1100_1010, 1'b0, 1'b1, 8'd3, 6'd40, 1'b0); // label -1
    do_req('1, 1'b1, 1'b0, 8'd0, 6'd45, 1'b0);               // R10: width 0 acts as 1
    do_req('0, 1'b0, 1'b1, 8'd1, 6'd50, 1'b1);               // width 1, all -1 inputs
    do_req(10'h155, 1'b1, 1'b1, 8'd4, 6'd63, 1'b0);          // R2: agreeing +1
    do_req(10'h2AA, 1'b0, 1'b0, 8'd2, 6'd7, 1'b0);           // R2: agreeing -1
    do_req(10'h2AA, 1'b0, 1'b1, 8'd5, 6'd21, 1'b1);          // R9: meddling while busy

    // Random mix
    for (int n = 0; n < 40; n++) begin
      logic d, y;
      d = 1'($urandom);
      y = ($urandom_range(0, 3) == 0) ? d : !d;
      do_req(NCOL'($urandom), d, y, WW'($urandom_range(0, 6)), VW'($urandom),
             1'($urandom_range(0, 3) != 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule